// File: doc/BRIEF.md
# Serial Management Frame Master

This block drives a two-wire management bus (a clock line and a bidirectional data line) from a small register port. Software first writes a control word, which sets the clock divisor and decides whether a run of idle ones goes out ahead of the frame. It then writes one complete 32-bit frame word, and that write starts the transaction. The frame word already carries every field: the start pattern, the read or write opcode, the device and register numbers, the turnaround marker and the write data. The engine does not interpret any of those fields, except that it checks the read opcode bit to decide when to release the data line and collect the reply.

The management clock is derived from the system clock. The engine shifts the word out most significant bit first, changing the data line only while the management clock is low. For a read, it stops driving the data line from the turnaround bits onward. It then samples sixteen reply bits on the rising edges of the management clock and places them in the low half of the data register. Software polls a sticky completion bit in the control register. Writing zero to the control register returns the engine to idle at any point, including partway through a frame.

A "select block" write is just another frame word. It targets register 0x1F and puts a device number at data bit 4 and up. The engine sends it unchanged, exactly as it would any other frame.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, the control register reads zero, the clock output is low and the data output enable is low. Whenever no transaction is in flight, the clock output stays low and the data line is not driven.
- R2: A data write at byte offset 0x12C starts a transaction only if the control register's divisor or preamble bit is nonzero. If both are zero, the write is ignored: no clock edge appears and the completion bit stays clear.
- R3: When control bit 7 is set, 32 clock periods with the data line driven high come before the frame. When bit 7 is clear, the first clock period already carries frame bit 31.
- R4: The frame word goes out bit 31 first and bit 0 last, one bit per clock period. The data line changes only while the clock is low. For a write (bit 28 set, bit 29 clear), all 32 bits are driven.
- R5: The clock toggles every (divisor+1) system clocks, where the divisor is control bits 6..0. Every half period of one transaction therefore lasts exactly divisor+1 cycles.
- R6: When frame bit 29 is set, the data line is released from frame bit 17 (turnaround) through bit 0. The line is sampled on the clock's rising edge for frame bits 15..0, MSB first. Once the transaction completes, those samples read back in bits 15..0 of the data register, and bits 31..16 keep the launched word.
- R7: Control bit 8 is the completion flag. Launching a frame clears it. It sets on the falling clock edge that ends the last bit, which is 2·N·(divisor+1) cycles after the launch edge, where N is 32 plus 32 if the preamble is on. It stays set until cleared.
- R8: Writing zero to the control register at byte offset 0x128 aborts any transaction. From the next cycle the clock is low, the line is released and the completion flag is clear.
- R9: A data write that arrives while a transaction is in flight is ignored. The frame on the wire and the stored word are those of the first launch.
- R10: Register reads return their value one cycle after the address is presented. The control register reads back as divisor in bits 6..0, preamble enable in bit 7 and completion in bit 8. The data register reads back the launched word, updated as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench builds the block with its default parameters: a 7-bit divisor field, a 32-bit frame and a 32-bit preamble. This keeps the wire sequences full length and lets the bench capture each one bit by bit. The vectors use divisors 0, 1, 2, 3 and 5, so the shortest possible half period is covered along with both odd and even clock stretches. Each vector's completion cycle count is checked against 2·N·(divisor+1)+1. A small register-file model on the bench answers read frames, so that written data, set-block frames and later reads of the same register can be followed end to end.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_FRAME = 2'd2
  } eng_state_t;
endpackage

// File: rtl/mdio_tick_gen.sv
module mdio_tick_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  // Count resets whenever the engine is idle so the first half period is full.
  always_ff @(posedge clk) begin
    if (rst || !run)      cnt <= '0;
    else if (cnt == div)  cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == div);
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int FRAME_W = 32,
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int RD_BIT  = 29,
  parameter int TA_BIT  = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               abort,
  input  logic               pre_en,
  input  logic               tick,
  input  logic [FRAME_W-1:0] frame,
  input  logic               mdio_i,
  output logic               busy,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  rd_data,
  output logic               done_pulse
);
  localparam int IDX_W = $clog2(FRAME_W > PRE_LEN ? FRAME_W : PRE_LEN);
  localparam logic [IDX_W-1:0] PRE_TOP  = IDX_W'(PRE_LEN - 1);
  localparam logic [IDX_W-1:0] FRM_TOP  = IDX_W'(FRAME_W - 1);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_BIT);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_W);

  eng_state_t         st;
  logic [IDX_W-1:0]   idx;
  logic [IDX_W-1:0]   idx_nx;
  logic [FRAME_W-1:0] sh;
  logic               rd_q;
  logic               last;

  assign busy       = (st != ST_IDLE);
  assign last       = (idx == '0);
  assign idx_nx     = idx - 1'b1;
  assign done_pulse = tick && mdc && last && (st == ST_FRAME);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      st      <= ST_IDLE;
      idx     <= '0;
      sh      <= '0;
      rd_q    <= 1'b0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (start) begin
      st      <= pre_en ? ST_PRE : ST_FRAME;
      idx     <= pre_en ? PRE_TOP : FRM_TOP;
      sh      <= frame;
      rd_q    <= frame[RD_BIT];
      mdc     <= 1'b0;
      mdio_o  <= pre_en ? 1'b1 : frame[FRAME_W-1];
      mdio_oe <= 1'b1;
    end else if (tick) begin
      if (!mdc) begin
        mdc <= 1'b1;
      end else begin
        mdc <= 1'b0;
        if (last) begin
          if (st == ST_PRE) begin
            st      <= ST_FRAME;
            idx     <= FRM_TOP;
            mdio_o  <= sh[FRAME_W-1];
            mdio_oe <= 1'b1;
          end else begin
            st      <= ST_IDLE;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
          end
        end else begin
          idx <= idx_nx;
          if (st == ST_FRAME) begin
            sh      <= {sh[FRAME_W-2:0], 1'b0};
            mdio_o  <= sh[FRAME_W-2];
            mdio_oe <= !(rd_q && (idx_nx <= TA_IDX));
          end
        end
      end
    end
  end

  // Reply bits are taken on the rising clock edge of frame bits DATA_W-1..0.
  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (tick && !mdc && (st == ST_FRAME) && rd_q && (idx < DATA_IDX))
      rd_data <= {rd_data[DATA_W-2:0], mdio_i};
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  // R4
  mdio_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && mdc && $past(mdc)) |-> $stable(mdio_o));

  // R6
  release_read_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !mdio_oe) |-> (rd_q && st == ST_FRAME));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master #(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h128,
  parameter logic [ADDR_W-1:0] DATA_OFS = 'h12C,
  parameter int                DIV_W    = 7,
  parameter int                FRAME_W  = 32,
  parameter int                PRE_LEN  = 32,
  parameter int                DATA_W   = 16,
  parameter int                RD_BIT   = 29,
  parameter int                TA_BIT   = 17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [FRAME_W-1:0] reg_wdata,
  output logic [FRAME_W-1:0] reg_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);
  localparam int PRE_POS  = DIV_W;
  localparam int DONE_POS = DIV_W + 1;

  logic               pre_q, done_q;
  logic [DIV_W-1:0]   div_q;
  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] ctrl_view;
  logic               ctrl_wr, data_wr, wr_zero, ctrl_live, start;
  logic               busy, tick, done_pulse;
  logic [DATA_W-1:0]  rd_data;

  assign ctrl_wr   = reg_we && (reg_addr == CTRL_OFS);
  assign data_wr   = reg_we && (reg_addr == DATA_OFS);
  assign wr_zero   = ctrl_wr && (reg_wdata[PRE_POS:0] == '0);
  assign ctrl_live = pre_q || (div_q != '0);
  assign start     = data_wr && ctrl_live && !busy;

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[DIV_W-1:0]     = div_q;
    ctrl_view[PRE_POS]       = pre_q;
    ctrl_view[DONE_POS]      = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q     <= 1'b0;
      div_q     <= '0;
      done_q    <= 1'b0;
      frame_q   <= '0;
      reg_rdata <= '0;
    end else begin
      if (ctrl_wr) begin
        pre_q <= reg_wdata[PRE_POS];
        div_q <= reg_wdata[DIV_W-1:0];
        if (wr_zero) done_q <= 1'b0;
      end
      if (start) begin
        frame_q <= reg_wdata;
        done_q  <= 1'b0;
      end else if (done_pulse) begin
        done_q <= 1'b1;
        if (frame_q[RD_BIT]) frame_q[DATA_W-1:0] <= rd_data;
      end
      if (reg_addr == CTRL_OFS)      reg_rdata <= ctrl_view;
      else if (reg_addr == DATA_OFS) reg_rdata <= frame_q;
      else                           reg_rdata <= '0;
    end
  end

  mdio_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .div  (div_q),
    .tick (tick)
  );

  mdio_frame_engine #(
    .FRAME_W (FRAME_W),
    .PRE_LEN (PRE_LEN),
    .DATA_W  (DATA_W),
    .RD_BIT  (RD_BIT),
    .TA_BIT  (TA_BIT)
  ) u_eng (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .abort      (wr_zero),
    .pre_en     (pre_q),
    .tick       (tick),
    .frame      (reg_wdata),
    .mdio_i     (mdio_i),
    .busy       (busy),
    .mdc        (mdc),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .rd_data    (rd_data),
    .done_pulse (done_pulse)
  );

  // R2
  idle_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !ctrl_live && !busy) |=> !busy);

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> $past(busy));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    wr_zero |=> (!busy && !done_q && !mdc && !mdio_oe));

  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && data_wr) |=> $stable(frame_q[FRAME_W-1:DATA_W]));
endmodule

// File: tb/tb_mdio_frame_master.sv
`timescale 1ns/1ps
module tb_mdio_frame_master;
  localparam logic [11:0] CTRL = 12'h128;
  localparam logic [11:0] DATA = 12'h12C;
  localparam int NV = 7;
  // {ctrl[15:0], expected data low half[15:0], frame[31:0]}
  localparam logic [63:0] VEC [NV] = '{
    64'h0082_BEEF_5006_BEEF,
    64'h0082_BEEF_6006_0000,
    64'h0002_A333_600E_0000,
    64'h0080_8001_501E_8001,
    64'h0005_8001_601E_0000,
    64'h0083_01D0_507E_01D0,
    64'h0001_01D0_607E_0000
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int nchk = 0, nfail = 0;
  logic [15:0] phy [32];
  logic        cur_pre = 1'b0, cur_rd = 1'b0;
  logic [4:0]  cur_reg = '0;
  int  arm_seq = 0, seen_seq = 0;
  logic cap_o [64];
  logic cap_oe [64];
  int  ncap = 0, nfall = 0, cyc = 0, last_chg = 0, hp_min = 0, hp_max = 0;
  logic mdc_prev = 1'b0, have_chg = 1'b0;

  always #2 clk = ~clk;

  mdio_frame_master dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // Wire monitor and register-file responder, sampled on the falling system edge.
  always @(negedge clk) begin
    int fb;
    cyc = cyc + 1;
    if (arm_seq != seen_seq) begin
      seen_seq = arm_seq; ncap = 0; nfall = 0; mdio_i = 1'b1;
      hp_min = 1000000; hp_max = 0; have_chg = 1'b0; mdc_prev = 1'b0;
    end else begin
      if (mdc != mdc_prev) begin
        if (have_chg) begin
          if (cyc - last_chg < hp_min) hp_min = cyc - last_chg;
          if (cyc - last_chg > hp_max) hp_max = cyc - last_chg;
        end
        have_chg = 1'b1; last_chg = cyc;
      end
      if (mdc && !mdc_prev) begin
        if (ncap < 64) begin cap_o[ncap] = mdio_o; cap_oe[ncap] = mdio_oe; end
        ncap = ncap + 1;
      end
      if (!mdc && mdc_prev) nfall = nfall + 1;
      mdc_prev = mdc;
      fb = nfall - (cur_pre ? 32 : 0);
      if (cur_rd && fb >= 16 && fb < 32) mdio_i = phy[cur_reg][31-fb];
      else mdio_i = 1'b1;
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] r);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    r = reg_rdata;
  endtask

  task automatic wait_done(output int k);
    reg_addr = CTRL; k = 0;
    do begin
      @(posedge clk); @(negedge clk);
      k = k + 1;
    end while (!reg_rdata[8] && k < 5000);
  endtask

  function automatic int seq_mismatch(input logic pre, input logic [31:0] f);
    int m = 0;
    int n = pre ? 64 : 32;
    for (int j = 0; j < n; j++) begin
      logic eo, eb;
      int pos;
      if (pre && j < 32) begin eo = 1'b1; eb = 1'b1; end
      else begin
        pos = 31 - (j - (pre ? 32 : 0));
        eo = !(f[29] && pos <= 17);
        eb = f[pos];
      end
      if (cap_oe[j] != eo) m = m + 1;
      else if (eo && cap_o[j] != eb) m = m + 1;
    end
    return m;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
    $finish;
  end

  initial begin
    logic [31:0] r, f;
    logic [15:0] c;
    int k, n, d, q;
    for (int i = 0; i < 32; i++) phy[i] = 16'hA000 + 16'(i) * 16'h0111;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    reg_read(CTRL, r);
    check(r == 32'h0 && !mdc && !mdio_oe, "R1 reset", {r[31:0], mdc, mdio_oe}, 0);

    for (int i = 0; i < NV; i++) begin
      c = VEC[i][63:48]; f = VEC[i][31:0];
      d = int'(c[6:0]); cur_pre = c[7]; cur_rd = f[29]; cur_reg = f[22:18];
      n = cur_pre ? 64 : 32;
      reg_write(CTRL, {16'h0, c});
      arm_seq = arm_seq + 1;
      reg_write(DATA, f);
      wait_done(k);
      check(k == 2*n*(d+1) + 1, "R7 completion cycle", k, 2*n*(d+1) + 1);
      check(ncap == n, "R3 preamble plus frame length", ncap, n);
      q = seq_mismatch(cur_pre, f);
      check(q == 0, cur_rd ? "R6 read frame on wire" : "R4 write frame on wire", q, 0);
      check(hp_min == d+1 && hp_max == d+1, "R5 half period", {hp_min, hp_max}, d+1);
      reg_read(DATA, r);
      check(r == {f[31:16], VEC[i][47:32]}, "R10 data readback", r, {f[31:16], VEC[i][47:32]});
      if (!cur_rd) phy[cur_reg] = f[15:0];
      reg_read(CTRL, r);
      check(r == {23'h0, 1'b1, c[7:0]}, "R10 control readback", r, {23'h0, 1'b1, c[7:0]});
      reg_write(CTRL, 32'h0);
      reg_read(CTRL, r);
      check(r == 32'h0, "R8 zero control clears flag", r, 0);
    end

    // R2: launch ignored when control is zero
    arm_seq = arm_seq + 1;
    reg_write(DATA, 32'h5006_1111);
    repeat (40) @(negedge clk);
    reg_read(CTRL, r);
    check(ncap == 0 && r == 32'h0, "R2 no launch while control zero", ncap, 0);

    // R8: abort mid-read
    cur_pre = 1'b1; cur_rd = 1'b1; cur_reg = 5'd1;
    reg_write(CTRL, 32'h0000_0082);
    arm_seq = arm_seq + 1;
    reg_write(DATA, 32'h6006_0000);
    repeat (30) @(negedge clk);
    reg_write(CTRL, 32'h0);
    check(!mdc && !mdio_oe, "R8 abort idles wire", {mdc, mdio_oe}, 0);
    k = ncap;
    repeat (40) @(negedge clk);
    reg_read(CTRL, r);
    check(ncap == k && r == 32'h0 && !mdc, "R8 no activity after abort", ncap, k);

    // R9: second data write while busy is dropped
    cur_pre = 1'b0; cur_rd = 1'b0; cur_reg = 5'd2;
    reg_write(CTRL, 32'h0000_0001);
    arm_seq = arm_seq + 1;
    reg_write(DATA, 32'h500A_1234);
    repeat (10) @(negedge clk);
    reg_write(DATA, 32'h6006_0000);
    wait_done(k);
    q = seq_mismatch(1'b0, 32'h500A_1234);
    check(q == 0 && ncap == 32, "R9 first frame kept on wire", q, 0);
    reg_read(DATA, r);
    check(r == 32'h500A_1234, "R9 stored word kept", r, 32'h500A_1234);
    reg_write(CTRL, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule